// File: doc/BRIEF.md
# Sprite Attribute Page Copier

This block fills the 256-byte sprite attribute memory from one page of CPU address space after a single register write. It watches the CPU's register writes. When the CPU writes a value N to address 0x4014, the block copies bytes N·0x100 through N·0x100+0xFF. It holds the CPU stalled until the copy ends. A write of 0x02 is the usual case, because sprite tables normally sit in the page at 0x0200. The source bytes form 64 entries of four bytes each. Each entry holds the Y position, the tile index, the attribute byte and the X position, in that order. The copy moves bytes without decoding them, so the order of each entry and every attribute bit (flips, background priority, palette bits) arrive unchanged.

The block moves data through two valid/ready ports. On the read port, the block raises a request and holds its address until the memory accepts it. The memory puts the byte on the read data input in the cycle it accepts the request. On the sprite memory write port, the block holds the address and the data stable until the sink accepts them. Either side may apply back-pressure for any number of cycles. Each stalled cycle lengthens the transfer by one cycle. Without back-pressure, each byte takes one read cycle and one write cycle. The destination starts at the current sprite memory address given on an input, and it wraps modulo 256.

Top module: `spr_dma`

## Requirements
- R1: A CPU write (cpu_wr_en high) to address 0x4014 while the block is idle starts a copy whose source page is the written byte. A write to any other address starts nothing.
- R2: A copy issues exactly 256 accepted reads at addresses N·0x100+i, with i rising from 0 to 255. It issues exactly 256 accepted sprite memory writes.
- R3: Source byte i is written to sprite memory address (oam_base + i) mod 256, where oam_base is sampled in the cycle of the triggering write. Bytes are not altered, so each four-byte entry keeps its Y, tile, attribute and X order.
- R4: cpu_rdy is low and busy is high from the cycle after the triggering write through the cycle of the last accepted sprite memory write. At all other times cpu_rdy is high and busy is low.
- R5: A phase bit toggles every clock and is 0 in the first cycle after reset. A trigger sampled while the phase is 1 counts as an odd start and inserts one alignment cycle before the first read. Without back-pressure, an even start stalls the CPU for 512 cycles and an odd start for 513.
- R6: A read request holds its address until rd_ready is high. A sprite memory write holds its address and data until oam_ready is high. At most one of the two is requested in any cycle, and the write of a byte directly follows the cycle in which its read is accepted.
- R7: A write to 0x4014 while busy is ignored. The running copy keeps its page and destination, and no second copy follows.
- R8: done is high for exactly one cycle, the cycle right after the last accepted sprite memory write, and busy is low in that cycle.
- R9: After reset the block is idle: cpu_rdy is high, busy, done, rd_valid and oam_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| oam_base | input | 8 | Current sprite memory address, sampled at trigger |
| cpu_rdy | output | 1 | CPU may run; low while copying |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when the copy ends |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 16 | Read request address |
| rd_ready | input | 1 | Memory accepts the request; rd_data valid this cycle |
| rd_data | input | 8 | Read data |
| oam_valid | output | 1 | Sprite memory write valid |
| oam_addr | output | 8 | Sprite memory write address |
| oam_data | output | 8 | Sprite memory write data |
| oam_ready | input | 1 | Sprite memory accepts the write |

## Verification
The assertions check the per-cycle rules on every cycle:
- both ports keep their address and data stable under back-pressure;
- read and write requests never overlap, and a write directly follows each accepted read;
- the source page stays fixed for the whole copy, even when a second trigger write arrives;
- a copy only starts after a trigger write;
- done appears only as the copy ends.

Only the bench scenarios can show the end-to-end results:
- all 256 bytes land at the right wrapped destinations;
- the stall lasts exactly 512 or 513 cycles, depending on the start phase;
- writes to other addresses start nothing;
- a write during a copy leaves every destination byte from the original page.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dma_st_t;
endpackage

// File: rtl/spr_dma_trig.sv
module spr_dma_trig #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  output logic              start,
  output logic              start_odd,
  output logic [DATA_W-1:0] page
);
  logic phase;

  // CPU cycle phase: 0 in the first cycle after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign start     = idle && wr_en && (addr == TRIG_ADDR);
  assign start_odd = phase;

  always_ff @(posedge clk) begin
    if (!rst_n)     page <= '0;
    else if (start) page <= wdata;
  end
endmodule

// File: rtl/spr_dma_ctr.sv
module spr_dma_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] base_in,
  input  logic             step,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] dst,
  output logic             last
);
  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      base_q <= '0;
    end else if (load) begin
      idx    <= '0;
      base_q <= base_in;
    end else if (step) begin
      idx    <= idx + 1'b1;
    end
  end

  assign dst  = base_q + idx;
  assign last = &idx;
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_odd,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              oam_ready,
  input  logic              last,
  output logic              rd_valid,
  output logic              oam_valid,
  output logic [DATA_W-1:0] wr_byte,
  output logic              step,
  output logic              idle,
  output logic              done
);
  dma_st_t st, st_nx;

  assign rd_valid  = (st == ST_READ);
  assign oam_valid = (st == ST_WRITE);
  assign idle      = (st == ST_IDLE);
  assign step      = oam_valid && oam_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = start_odd ? ST_ALIGN : ST_READ;
      ST_ALIGN: st_nx = ST_READ;
      ST_READ:  if (rd_ready) st_nx = ST_WRITE;
      ST_WRITE: if (oam_ready) st_nx = last ? ST_IDLE : ST_READ;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_byte <= '0;
      done    <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= step && last;
      if (rd_valid && rd_ready) wr_byte <= rd_data;
    end
  end
endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_wr_en,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  input  logic [$clog2(PAGE_BYTES)-1:0] oam_base,
  output logic                        cpu_rdy,
  output logic                        busy,
  output logic                        done,
  output logic                        rd_valid,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic                        rd_ready,
  input  logic [DATA_W-1:0]           rd_data,
  output logic                        oam_valid,
  output logic [$clog2(PAGE_BYTES)-1:0] oam_addr,
  output logic [DATA_W-1:0]           oam_data,
  input  logic                        oam_ready
);
  localparam int CNT_W = $clog2(PAGE_BYTES);

  logic              start, start_odd, idle, step, last;
  logic [DATA_W-1:0] page;
  logic [CNT_W-1:0]  idx;

  spr_dma_trig #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR)) u_trig (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .idle(idle), .start(start), .start_odd(start_odd),
    .page(page)
  );

  spr_dma_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start), .base_in(oam_base),
    .step(step), .idx(idx), .dst(oam_addr), .last(last)
  );

  spr_dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_odd(start_odd),
    .rd_ready(rd_ready), .rd_data(rd_data), .oam_ready(oam_ready),
    .last(last), .rd_valid(rd_valid), .oam_valid(oam_valid),
    .wr_byte(oam_data), .step(step), .idle(idle), .done(done)
  );

  assign rd_addr = ADDR_W'({page, idx});
  assign busy    = ~idle;
  assign cpu_rdy = idle;
endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              oam_valid,
  input logic [CNT_W-1:0]  oam_addr,
  input logic [DATA_W-1:0] oam_data,
  input logic              oam_ready
);
  a_r1_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cpu_wr_en && (cpu_addr == TRIG_ADDR)));

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  a_r6_oam_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (oam_valid && !oam_ready) |=> (oam_valid && $stable(oam_addr) && $stable(oam_data)));

  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && oam_valid));

  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> oam_valid);

  a_r4_requests_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || oam_valid) |-> busy);

  a_r7_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr[ADDR_W-1:CNT_W]));

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind spr_dma spr_dma_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W($clog2(PAGE_BYTES)), .TRIG_ADDR(TRIG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
  .busy(busy), .done(done), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .oam_valid(oam_valid), .oam_addr(oam_addr),
  .oam_data(oam_data), .oam_ready(oam_ready)
);

// File: tb/spr_dma_tb.sv
`timescale 1ns/100ps
module spr_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  oam_base = '0;
  logic        cpu_rdy, busy, done, rd_valid, oam_valid;
  logic [15:0] rd_addr;
  logic        rd_ready = 1'b1, oam_ready = 1'b1;
  logic [7:0]  rd_data, oam_addr, oam_data;

  int checks = 0, errors = 0;
  int edges = 0, stall_cyc = 0, done_cyc = 0, rd_cnt = 0, wr_cnt = 0;
  bit bp_on = 1'b0;
  bit wd_hit = 1'b0;
  logic [7:0] oam_mem [256];
  logic [7:0] exp_page;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'h3b) ^ 8'h5a;
  endfunction

  assign rd_data = memfn(rd_addr);

  spr_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .oam_base(oam_base), .cpu_rdy(cpu_rdy), .busy(busy),
    .done(done), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .oam_valid(oam_valid), .oam_addr(oam_addr),
    .oam_data(oam_data), .oam_ready(oam_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) edges++;

  always @(posedge clk) begin
    #1;
    rd_ready  = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    oam_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Monitor at the falling edge: a handshake seen here completes at the next rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cpu_rdy) stall_cyc++;
      if (done) begin
        done_cyc++;
        chk(wr_cnt == 256, "R8 done after last write", wr_cnt, 256);
      end
      if (rd_valid && rd_ready) begin
        if (rd_addr != {exp_page, rd_cnt[7:0]})
          chk(1'b0, "R2 read address", rd_addr, {exp_page, rd_cnt[7:0]});
        rd_cnt++;
      end
      if (oam_valid && oam_ready) begin
        oam_mem[oam_addr] = oam_data;
        wr_cnt++;
      end
    end
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // Run one copy; want_odd selects the start phase.
  task automatic run_copy(input logic [7:0] page, input logic [7:0] base,
                          input bit want_odd, input bit bp, input bit poke);
    int exp_stall;
    @(negedge clk);
    if ((edges % 2) != int'(want_odd)) @(negedge clk);
    for (int i = 0; i < 256; i++) oam_mem[i] = 8'hEE;
    stall_cyc = 0; done_cyc = 0; rd_cnt = 0; wr_cnt = 0;
    exp_page = page; bp_on = bp; oam_base = base;
    cpu_write(16'h4014, page);
    oam_base = ~base;
    chk(busy == 1'b1 && cpu_rdy == 1'b0, "R4 stall begins", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      cpu_write(16'h4014, page ^ 8'h55);  // R7 write while busy
    end
    wait_idle();
    bp_on = 1'b0;
    chk(rd_cnt == 256, "R2 read count", rd_cnt, 256);
    chk(wr_cnt == 256, "R2 write count", wr_cnt, 256);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = base + i[7:0];
      logic [7:0] e = memfn({page, i[7:0]});
      chk(oam_mem[d] == e, "R3 byte placement", oam_mem[d], e);
    end
    chk(done_cyc == 1, "R8 done pulse width", done_cyc, 1);
    if (!bp) begin
      exp_stall = want_odd ? 513 : 512;
      chk(stall_cyc == exp_stall, "R5 stall length", stall_cyc, exp_stall);
    end
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && cpu_rdy == 1'b1, "R7 no second copy / R4 ready", busy, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cpu_rdy == 1'b1, "R9 cpu_rdy", cpu_rdy, 1);
    chk(busy == 1'b0 && done == 1'b0, "R9 busy/done", {busy, done}, 0);
    chk(rd_valid == 1'b0 && oam_valid == 1'b0, "R9 valids", {rd_valid, oam_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 other addresses ignored
    cpu_write(16'h4015, 8'h02);
    cpu_write(16'h2004, 8'h02);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rd_valid == 1'b0, "R1 non-trigger address", busy, 0);
    run_copy(8'h02, 8'h00, 1'b0, 1'b0, 1'b0);
    run_copy(8'h07, 8'h00, 1'b1, 1'b0, 1'b0);
    run_copy(8'h03, 8'hFC, 1'b0, 1'b1, 1'b0);
    run_copy(8'h02, 8'h10, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++)
      run_copy(8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    if (wd_hit) chk(1'b0, "watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge wd_hit) begin
    chk(1'b0, "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule